// File: doc/BRIEF.md
# Sequence-Armed Watchdog Timer

This peripheral is a watchdog timer on a small register bus. A free-running up-counter advances on a slow timebase tick. The tick can optionally be divided by a power-of-two prescaler. When the armed counter rolls over its top value, the block raises a one-clock reset request and restarts from a programmed start value. Software keeps the system alive by writing a new value to a kick register, which copies the start value into the counter. Two ordered pairs of magic words arm and disarm the counter, so a stray single write cannot start or stop it.

Every write to the control, start-value, kick or arm registers is posted. It is held in a per-register slot and takes effect only after a fixed number of timebase ticks. A status register exposes one busy flag per slot. The register bus has no back-pressure: a write is always taken in the cycle it is presented. A write that targets a busy slot is silently dropped, so software is expected to poll the status flag before writing that register again. Reads are combinational from the word address.

Top module: `wdog_timer`

## Requirements
- R1: After reset the counter is disarmed, the control, start-value, kick and counter registers read zero, every busy flag is clear and `rst_req` is low.
- R2: Reads by word index: 0 returns the revision `REV_ID` in bits 7:0 with zeros above it; 1 control (bits 5:0); 2 start value; 3 last accepted kick word; 4 zero; 5 status; 6 live counter; 7 zero.
- R3: Status bits (index 5): bit 0 control, bit 2 start value, bit 3 kick, bit 4 arm. A write sets its flag from the next cycle on. The write takes effect, and the flag clears, on the clock that carries the second tick after the acceptance cycle. A tick in the acceptance cycle itself is not counted.
- R4: A write to a register whose busy flag is set is ignored.
- R5: The counter is armed when the arm register commits 0xBBBB and then 0x4444 in its low 16 bits, in that order.
- R6: The counter is disarmed when the arm register commits 0xAAAA and then 0x5555, in that order.
- R7: If the second committed word is not the partner of the first, the sequence tracker returns to idle and the armed state is unchanged. This holds even when the second word is itself a first word.
- R8: While armed, the counter increases by one on each counting step. While disarmed it holds its value.
- R9: Control bit 5 turns on the prescaler and bits 4:2 hold an exponent k. With the prescaler on, one counting step occurs every 2^k ticks; with it off, every tick is a step. A committed control write restarts the division phase.
- R10: A new start value has no effect on the running count until a kick reloads it.
- R11: A committed kick word that differs from the previous kick word (zero after reset) copies the start value into the counter, whether armed or not. A kick equal to the previous word does nothing.
- R12: When an armed counter at all ones takes a counting step, it reloads the start value and `rst_req` is high for exactly one clock. A differing kick in that same cycle takes precedence, and no request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-clock timebase pulse |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 3 | Word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| rst_req | output | 1 | One-clock reset request on rollover |

## Verification
The bench uses the default 32-bit counter, a two-tick posting delay and a tick on every third clock. With these values each posted write settles within a handful of clocks. Loading a start value sixteen steps below the top brings a real 32-bit rollover within a few dozen ticks. The prescaler exponent 2 gives a divide-by-four rate whose step count can be measured over a short window.

// File: rtl/wd_pkg.sv
package wd_pkg;
  localparam int BUS_W  = 32;
  localparam int ADDR_W = 3;
  localparam int NSLOT  = 4;

  localparam logic [ADDR_W-1:0] A_REV  = 3'd0;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd1;
  localparam logic [ADDR_W-1:0] A_LOAD = 3'd2;
  localparam logic [ADDR_W-1:0] A_TRIG = 3'd3;
  localparam logic [ADDR_W-1:0] A_ARM  = 3'd4;
  localparam logic [ADDR_W-1:0] A_PEND = 3'd5;
  localparam logic [ADDR_W-1:0] A_CNT  = 3'd6;

  localparam int S_CTRL = 0;
  localparam int S_LOAD = 1;
  localparam int S_TRIG = 2;
  localparam int S_ARM  = 3;

  localparam logic [15:0] ON_A  = 16'hBBBB;
  localparam logic [15:0] ON_B  = 16'h4444;
  localparam logic [15:0] OFF_A = 16'hAAAA;
  localparam logic [15:0] OFF_B = 16'h5555;

  localparam int CTRL_W     = 6;
  localparam int PRE_EN_BIT = 5;
  localparam int EXP_LO     = 2;
  localparam int EXP_W      = 3;

  typedef enum logic [1:0] {SQ_IDLE, SQ_ON1, SQ_OFF1} seq_t;

  function automatic logic [ADDR_W-1:0] slot_addr(input int s);
    case (s)
      S_CTRL:  return A_CTRL;
      S_LOAD:  return A_LOAD;
      S_TRIG:  return A_TRIG;
      default: return A_ARM;
    endcase
  endfunction
endpackage

// File: rtl/wd_post_slot.sv
module wd_post_slot #(
  parameter int W          = 32,
  parameter int PEND_TICKS = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         wr_req,
  input  logic [W-1:0] wr_data,
  output logic         busy,
  output logic         commit,
  output logic [W-1:0] held
);
  localparam int PC_W = $clog2(PEND_TICKS + 1);

  logic [PC_W-1:0] pc;

  assign commit = busy && tick && (pc == PC_W'(PEND_TICKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      pc   <= '0;
      held <= '0;
    end else begin
      if (commit) begin
        busy <= 1'b0;
      end else if (busy && tick) begin
        pc <= pc + 1'b1;
      end
      if (!busy && wr_req) begin
        busy <= 1'b1;
        pc   <= '0;
        held <= wr_data;
      end
    end
  end
endmodule

// File: rtl/wd_prescaler.sv
module wd_prescaler #(
  parameter int EXP_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clr,
  input  logic             pre_en,
  input  logic [EXP_W-1:0] exp_k,
  output logic             step
);
  localparam int PC_W = (1 << EXP_W) - 1;

  logic [PC_W-1:0] pcnt;
  logic [PC_W-1:0] lim;

  always_comb begin
    lim = '0;
    for (int i = 0; i < PC_W; i++) begin
      if (i < int'(exp_k)) lim[i] = 1'b1;
    end
  end

  assign step = tick && (!pre_en || (pcnt == lim));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt <= '0;
    end else if (clr) begin
      pcnt <= '0;
    end else if (tick) begin
      pcnt <= (pre_en && !step) ? pcnt + 1'b1 : '0;
    end
  end
endmodule

// File: rtl/wd_arm_seq.sv
module wd_arm_seq
  import wd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        commit,
  input  logic [15:0] word,
  output logic        armed
);
  seq_t st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= SQ_IDLE;
      armed <= 1'b0;
    end else if (commit) begin
      case (st)
        SQ_IDLE: begin
          if (word == ON_A)       st <= SQ_ON1;
          else if (word == OFF_A) st <= SQ_OFF1;
          else                    st <= SQ_IDLE;
        end
        SQ_ON1: begin
          if (word == ON_B) armed <= 1'b1;
          st <= SQ_IDLE;
        end
        default: begin
          if (word == OFF_B) armed <= 1'b0;
          st <= SQ_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wd_pkg::*;
#(
  parameter int         CNT_W      = 32,
  parameter int         PEND_TICKS = 2,
  parameter logic [7:0] REV_ID     = 8'h3C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              rst_req
);
  logic [NSLOT-1:0] wr_sel;
  logic [NSLOT-1:0] busy;
  logic [NSLOT-1:0] commit;
  logic [BUS_W-1:0] held [NSLOT];

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    assign wr_sel[s] = bus_wr && (bus_addr == slot_addr(s));
    wd_post_slot #(.W(BUS_W), .PEND_TICKS(PEND_TICKS)) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .wr_req  (wr_sel[s]),
      .wr_data (bus_wdata),
      .busy    (busy[s]),
      .commit  (commit[s]),
      .held    (held[s])
    );
  end

  logic [4:0] pend_vec;
  assign pend_vec = {busy[S_ARM], busy[S_TRIG], busy[S_LOAD], 1'b0, busy[S_CTRL]};

  logic [CTRL_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  load_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BUS_W-1:0]  trig_q;
  logic              arm_en;
  logic              step;
  logic              reload_trig;
  logic              wrap_now;

  wd_prescaler #(.EXP_W(EXP_W)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .clr    (commit[S_CTRL]),
    .pre_en (ctrl_q[PRE_EN_BIT]),
    .exp_k  (ctrl_q[EXP_LO +: EXP_W]),
    .step   (step)
  );

  wd_arm_seq u_arm (
    .clk    (clk),
    .rst_n  (rst_n),
    .commit (commit[S_ARM]),
    .word   (held[S_ARM][15:0]),
    .armed  (arm_en)
  );

  assign reload_trig = commit[S_TRIG] && (held[S_TRIG] != trig_q);
  assign wrap_now    = arm_en && step && !reload_trig && (cnt_q == '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      load_q  <= '0;
      cnt_q   <= '0;
      trig_q  <= '0;
      rst_req <= 1'b0;
    end else begin
      rst_req <= wrap_now;
      if (commit[S_CTRL]) ctrl_q <= held[S_CTRL][CTRL_W-1:0];
      if (commit[S_LOAD]) load_q <= held[S_LOAD][CNT_W-1:0];
      if (reload_trig) begin
        cnt_q  <= load_q;
        trig_q <= held[S_TRIG];
      end else if (arm_en && step) begin
        cnt_q <= wrap_now ? load_q : cnt_q + 1'b1;
      end
    end
  end

  always_comb begin
    case (bus_addr)
      A_REV:   bus_rdata = {{(BUS_W-8){1'b0}}, REV_ID};
      A_CTRL:  bus_rdata = {{(BUS_W-CTRL_W){1'b0}}, ctrl_q};
      A_LOAD:  bus_rdata = BUS_W'(load_q);
      A_TRIG:  bus_rdata = trig_q;
      A_PEND:  bus_rdata = {{(BUS_W-5){1'b0}}, pend_vec};
      A_CNT:   bus_rdata = BUS_W'(cnt_q);
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk
  import wd_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              rst_req,
  input logic              en,
  input logic [CNT_W-1:0]  cnt,
  input logic [4:0]        pend
);
  // R12
  rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  // R12
  rst_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(en));

  // R3
  ctrl_pend_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend[0]) |-> $past(bus_wr && (bus_addr == A_CTRL)));

  // R5
  arm_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en != $past(en)) |-> $fell(pend[4]));

  // R8
  frozen_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(en) && !$fell(pend[3])) |-> (cnt == $past(cnt)));
endmodule

bind wdog_timer wdog_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .rst_req  (rst_req),
  .en       (arm_en),
  .cnt      (cnt_q),
  .pend     (pend_vec)
);

// File: tb/wdog_timer_test.sv
`timescale 1ns/1ps
module wdog_timer_test;
  localparam logic [7:0] REV = 8'h3C;
  localparam int PT = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        rst_req;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int tdiv = 0;
  int pulses = 0;

  always #2.5 clk = ~clk;

  wdog_timer #(.CNT_W(32), .PEND_TICKS(PT), .REV_ID(REV)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .rst_req(rst_req)
  );

  // reference model state
  bit          m_busy [4];
  int          m_pc   [4];
  logic [31:0] m_held [4];
  logic [5:0]  m_ctrl = '0;
  logic [31:0] m_load = '0;
  logic [31:0] m_cnt  = '0;
  logic [31:0] m_trig = '0;
  bit          m_en = 0;
  int          m_seq = 0;
  int          m_pcnt = 0;
  bit          m_rst = 0;

  function automatic logic [2:0] addr_of(int s);
    case (s)
      0: return 3'd1;
      1: return 3'd2;
      2: return 3'd3;
      default: return 3'd4;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < 4; s++) begin m_busy[s] = 0; m_pc[s] = 0; m_held[s] = '0; end
      m_ctrl = '0; m_load = '0; m_cnt = '0; m_trig = '0;
      m_en = 0; m_seq = 0; m_pcnt = 0; m_rst = 0;
    end else begin
      bit cm [4];
      bit pen, stp, rt, nr, ob;
      int lim;
      logic [15:0] w;
      for (int s = 0; s < 4; s++) cm[s] = tick && m_busy[s] && (m_pc[s] == PT - 1);
      pen = m_ctrl[5];
      lim = (1 << m_ctrl[4:2]) - 1;
      stp = tick && (!pen || (m_pcnt == lim));
      if (cm[0]) m_pcnt = 0;
      else if (tick) m_pcnt = (pen && !stp) ? m_pcnt + 1 : 0;
      rt = cm[2] && (m_held[2] != m_trig);
      nr = 0;
      if (rt) begin
        m_cnt = m_load; m_trig = m_held[2];
      end else if (m_en && stp) begin
        if (m_cnt == 32'hFFFF_FFFF) begin m_cnt = m_load; nr = 1; end
        else m_cnt = m_cnt + 32'd1;
      end
      m_rst = nr;
      if (cm[0]) m_ctrl = m_held[0][5:0];
      if (cm[1]) m_load = m_held[1];
      if (cm[3]) begin
        w = m_held[3][15:0];
        case (m_seq)
          0: m_seq = (w == 16'hBBBB) ? 1 : (w == 16'hAAAA) ? 2 : 0;
          1: begin if (w == 16'h4444) m_en = 1; m_seq = 0; end
          default: begin if (w == 16'h5555) m_en = 0; m_seq = 0; end
        endcase
      end
      for (int s = 0; s < 4; s++) begin
        ob = m_busy[s];
        if (cm[s]) m_busy[s] = 0;
        else if (m_busy[s] && tick) m_pc[s] = m_pc[s] + 1;
        if (!ob && bus_wr && (bus_addr == addr_of(s))) begin
          m_busy[s] = 1; m_pc[s] = 0; m_held[s] = bus_wdata;
        end
      end
    end
  end

  function automatic logic [31:0] m_read(logic [2:0] a);
    case (a)
      3'd0: return {24'd0, REV};
      3'd1: return {26'd0, m_ctrl};
      3'd2: return m_load;
      3'd3: return m_trig;
      3'd5: return {27'd0, m_busy[3], m_busy[2], m_busy[1], 1'b0, m_busy[0]};
      3'd6: return m_cnt;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(logic [2:0] a);
    case (a)
      3'd1: return "R9";
      3'd2: return "R10";
      3'd3: return "R11";
      3'd5: return "R3";
      3'd6: return "R8";
      default: return "R2";
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic chk_range(string tag, logic [31:0] got, logic [31:0] lo, logic [31:0] hi);
    checks++;
    if (got < lo || got > hi) begin
      fails++;
      $display("FAIL %s: got %h expected %h..%h", tag, got, lo, hi);
    end
  endtask

  // every-clock comparison against the model
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      chk(tag_of(bus_addr), bus_rdata, m_read(bus_addr));
      chk("R12", {31'd0, rst_req}, {31'd0, m_rst});
    end
  end

  // timebase: one tick every third clock
  always @(negedge clk) begin
    tick <= (tdiv == 0);
    tdiv <= (tdiv == 2) ? 0 : tdiv + 1;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && rst_req) pulses <= pulses + 1;
    if (cyc > 60000) begin
      fails++;
      $display("FAIL R1 watchdog: cycles %0d expected below %0d", cyc, 60000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic settle();
    repeat (10) @(negedge clk);
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  initial begin
    logic [31:0] v, c1, c2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 / R2: reset state and revision
    rd(3'd0, v); chk("R2", v, {24'd0, REV});
    rd(3'd1, v); chk("R1", v, 32'd0);
    rd(3'd2, v); chk("R1", v, 32'd0);
    rd(3'd6, v); chk("R1", v, 32'd0);
    rd(3'd5, v); chk("R1", v, 32'd0);
    chk("R1", {31'd0, rst_req}, 32'd0);

    // R3 / R4: posted control write, second write dropped while busy
    wr(3'd1, 32'h0C);
    rd(3'd5, v); chk("R3", v, 32'h1);
    wr(3'd1, 32'h3C);
    settle();
    rd(3'd1, v); chk("R4", v, 32'h0C);
    rd(3'd5, v); chk("R3", v, 32'h0);

    // R11 / R8: kick while disarmed loads; count frozen
    wr(3'd2, 32'h10); settle();
    wr(3'd3, 32'h1);  settle();
    rd(3'd6, v); chk("R11", v, 32'h10);
    repeat (15) @(negedge clk);
    rd(3'd6, v); chk("R8", v, 32'h10);

    // R5: arm
    wr(3'd4, 32'hBBBB); settle();
    wr(3'd4, 32'h4444); settle();
    rd(3'd6, v); chk_range("R5", v, 32'h11, 32'h40);

    // R10 / R11
    wr(3'd2, 32'h5000); settle();
    rd(3'd6, v); chk_range("R10", v, 32'h11, 32'h4FFF);
    wr(3'd3, 32'h1); settle();
    rd(3'd6, v); chk_range("R11", v, 32'h11, 32'h4FFF);
    wr(3'd3, 32'h2); settle();
    rd(3'd6, v); chk_range("R11", v, 32'h5000, 32'h5010);

    // R6: disarm
    wr(3'd4, 32'hAAAA); settle();
    wr(3'd4, 32'h5555); settle();
    rd(3'd6, c1);
    repeat (20) @(negedge clk);
    rd(3'd6, v); chk("R6", v, c1);

    // R7: mismatched pair, then a lone second word
    wr(3'd4, 32'hBBBB); settle();
    wr(3'd4, 32'h5555); settle();
    wr(3'd4, 32'h4444); settle();
    rd(3'd6, v); chk("R7", v, c1);
    wr(3'd4, 32'hBBBB); settle();
    wr(3'd4, 32'hBBBB); settle();
    wr(3'd4, 32'h4444); settle();
    rd(3'd6, v); chk("R7", v, c1);
    wr(3'd4, 32'hBBBB); settle();
    wr(3'd4, 32'h4444); settle();
    rd(3'd6, v); chk_range("R5", v, c1 + 32'd1, c1 + 32'd20);

    // R9: divide by four, then undivided
    wr(3'd1, 32'h28); settle();
    rd(3'd6, c1);
    repeat (120) @(negedge clk);
    rd(3'd6, c2); chk_range("R9", c2 - c1, 32'd9, 32'd11);
    wr(3'd1, 32'h00); settle();
    rd(3'd6, c1);
    repeat (30) @(negedge clk);
    rd(3'd6, c2); chk_range("R9", c2 - c1, 32'd9, 32'd11);

    // R12: rollover near the top of the range
    wr(3'd2, 32'hFFFF_FFF0); settle();
    pulses = 0;
    wr(3'd3, 32'h3);
    repeat (80) @(negedge clk);
    chk("R12", pulses, 32'd1);
    rd(3'd6, v); chk_range("R12", v, 32'hFFFF_FFF0, 32'hFFFF_FFFE);

    repeat (5) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule